// File: doc/BRIEF.md
# Two-Bank Interrupt Router with Fast-Path Steering

This block gathers up to 64 level-sensitive peripheral interrupt lines, organised as one or two groups of 32, and turns them into three processor-facing signals: a normal interrupt request, a fast interrupt request and an idle-wake request. Each group keeps its own enable vector and its own steering vector. An enable bit lets a line take part in the request outputs. A steering bit then sends that line to either the normal or the fast output. A line stays pending for as long as its input is high. Software clears a line by servicing the peripheral, never by writing this block.

A small register port (address, write data, write strobe, read data) gives software access to the enables, the steering bits and a single wake-policy bit. It also offers three read-only views per group: the raw line state, the lines that are enabled and steered to the normal output, and the lines that are enabled and steered to the fast output. Every line passes through a two-flop synchronizer before any of this logic uses it.

Top module: `intc_fiq_route`

## Requirements
- R1: After reset, all enable bits, all steering bits and the wake-policy bit are 0, `irq_o`, `fiq_o` and `wake_o` are low and `rdata` is 0.
- R2: Word offset 0x04 (enables) and offset 0x08 (steering) of a group are written with `wdata` at the clock edge where `wr_en` is high, and they read back the written value. They never change while `wr_en` is low.
- R3: A line whose enable bit is 0 never drives `irq_o` or `fiq_o`, whatever its input and steering bit are.
- R4: An enabled pending line whose steering bit is 0 drives `irq_o`. With steering bit 1 it drives `fiq_o` instead.
- R5: A line's pending state equals its input delayed by two clock edges, so it rises and falls with the input. Offset 0x10 reads the raw pending vector, independent of enables.
- R6: When the wake-policy bit (bit 0 at offset 0x14) is 1, `wake_o` is high only if some line is both pending and enabled.
- R7: When the wake-policy bit is 0, `wake_o` is high whenever any line is pending, enabled or not.
- R8: Offset 0x00 reads pending AND enable AND NOT steering. Offset 0x0C reads pending AND enable AND steering.
- R9: The second group occupies offsets 0x20 to 0x34 with the same layout, covering lines 32 to 63. It is independent of the first group. Offset 0x34 reads 0.
- R10: Writes to the read-only offsets (0x00, 0x0C, 0x10) change nothing. Reads of unmapped or unaligned addresses return 0.
- R11: `rdata` holds the value for the address presented in the previous cycle, sampled before any write made in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe for the current cycle |
| rdata | output | 32 | Registered read data |
| src_in | input | 64 | Peripheral interrupt lines, bit n is line n |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Idle-wake request |

## Verification
An enable write and the arrival of a line at the input can fall in the same clock cycle, so the new enable meets the line while the line is still inside the synchronizer. The bench raises a line in the same cycle as the write that enables it. It then samples `irq_o` after one edge, where the enable is in place but the line is not yet pending, so the output must stay low. It samples again after the second edge, where the output must be high. A random phase repeats this mix with enables, steering, policy and inputs changing together, and compares every output and view against bench-side functions.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BANK_W = 32;

  // Register select taken from addr[4:2] inside one group window.
  typedef enum logic [2:0] {
    SEL_IRQ_VIEW = 3'd0,
    SEL_ENABLE   = 3'd1,
    SEL_STEER    = 3'd2,
    SEL_FIQ_VIEW = 3'd3,
    SEL_RAW      = 3'd4,
    SEL_POLICY   = 3'd5
  } reg_sel_e;

  // Lines that are pending, enabled and steered to the chosen output.
  function automatic logic [BANK_W-1:0] routed(input logic [BANK_W-1:0] pend,
                                               input logic [BANK_W-1:0] en,
                                               input logic [BANK_W-1:0] steer,
                                               input logic to_fast);
    return pend & en & (to_fast ? steer : ~steer);
  endfunction

  // Wake contribution of one group under the selected policy.
  function automatic logic wake_term(input logic [BANK_W-1:0] pend,
                                     input logic [BANK_W-1:0] en,
                                     input logic only_enabled);
    return only_enabled ? |(pend & en) : |pend;
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign q_out = stage2_q;
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_enable,
  input  logic              wr_steer,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] pend,
  input  logic [2:0]        sel,
  input  logic              only_enabled,
  output logic [BANK_W-1:0] rd_word,
  output logic [BANK_W-1:0] en_o,
  output logic [BANK_W-1:0] steer_o,
  output logic              irq_hit,
  output logic              fiq_hit,
  output logic              wake_hit
);
  logic [BANK_W-1:0] en_q;
  logic [BANK_W-1:0] steer_q;
  logic [BANK_W-1:0] irq_view;
  logic [BANK_W-1:0] fiq_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      steer_q <= '0;
    end else begin
      if (wr_enable) en_q    <= wdata;
      if (wr_steer)  steer_q <= wdata;
    end
  end

  assign irq_view = routed(pend, en_q, steer_q, 1'b0);
  assign fiq_view = routed(pend, en_q, steer_q, 1'b1);
  assign irq_hit  = |irq_view;
  assign fiq_hit  = |fiq_view;
  assign wake_hit = wake_term(pend, en_q, only_enabled);
  assign en_o     = en_q;
  assign steer_o  = steer_q;

  always_comb begin
    unique case (reg_sel_e'(sel))
      SEL_IRQ_VIEW: rd_word = irq_view;
      SEL_ENABLE:   rd_word = en_q;
      SEL_STEER:    rd_word = steer_q;
      SEL_FIQ_VIEW: rd_word = fiq_view;
      SEL_RAW:      rd_word = pend;
      default:      rd_word = '0;
    endcase
  end

  // R3: an enable-free line never reaches either request
  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (!irq_hit && !fiq_hit));
  // R2: configuration holds without a write strobe
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_enable && !wr_steer) |=> ($stable(en_q) && $stable(steer_q)));
endmodule

// File: rtl/intc_fiq_route.sv
module intc_fiq_route
  import intc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BANK_W-1:0]           wdata,
  input  logic                        wr_en,
  output logic [BANK_W-1:0]           rdata,
  input  logic [NUM_BANKS*BANK_W-1:0] src_in,
  output logic                        irq_o,
  output logic                        fiq_o,
  output logic                        wake_o
);
  localparam int SRC_W = NUM_BANKS * BANK_W;
  localparam int GRP_W = ADDR_W - 5;

  logic [SRC_W-1:0]     pend_all;
  logic [SRC_W-1:0]     en_all;
  logic [SRC_W-1:0]     steer_all;
  logic [NUM_BANKS-1:0] irq_vec, fiq_vec, wake_vec;
  logic [BANK_W-1:0]    bank_rd [NUM_BANKS];
  logic                 policy_q;
  logic [BANK_W-1:0]    rd_next;
  logic [BANK_W-1:0]    rdata_q;

  // Address decode events, brought out for the checks.
  logic [GRP_W-1:0] grp;
  logic [2:0]       sel;
  logic             aligned;
  logic             policy_wr;

  assign grp       = addr[ADDR_W-1:5];
  assign sel       = addr[4:2];
  assign aligned   = (addr[1:0] == 2'b00);
  assign policy_wr = wr_en && aligned && (grp == '0) && (sel == SEL_POLICY);

  intc_sync #(.W(SRC_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (src_in),
    .q_out(pend_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = aligned && (int'(grp) == b);
    intc_bank u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_enable   (wr_en && hit && (sel == SEL_ENABLE)),
      .wr_steer    (wr_en && hit && (sel == SEL_STEER)),
      .wdata       (wdata),
      .pend        (pend_all[b*BANK_W +: BANK_W]),
      .sel         (sel),
      .only_enabled(policy_q),
      .rd_word     (bank_rd[b]),
      .en_o        (en_all[b*BANK_W +: BANK_W]),
      .steer_o     (steer_all[b*BANK_W +: BANK_W]),
      .irq_hit     (irq_vec[b]),
      .fiq_hit     (fiq_vec[b]),
      .wake_hit    (wake_vec[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         policy_q <= 1'b0;
    else if (policy_wr) policy_q <= wdata[0];
  end

  always_comb begin
    rd_next = '0;
    if (aligned) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (int'(grp) == b) rd_next = bank_rd[b];
      end
      if (grp == '0 && sel == SEL_POLICY) rd_next = {{(BANK_W-1){1'b0}}, policy_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_next;
  end

  assign rdata  = rdata_q;
  assign irq_o  = |irq_vec;
  assign fiq_o  = |fiq_vec;
  assign wake_o = |wake_vec;

  // R6: strict policy with nothing enabled keeps wake low
  p_strict_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_q && en_all == '0) |-> !wake_o);
  // R7: relaxed policy wakes on any pending line
  p_loose_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!policy_q && pend_all != '0) |-> wake_o);
  // R4: any request implies the core is also asked to wake
  p_req_wakes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o) |-> wake_o);
  // R5: pending is the input two edges earlier
  p_pend_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) |-> (pend_all == $past(src_in, 2)));
  // R10: policy changes only on its own write
  p_policy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !policy_wr |=> $stable(policy_q));
endmodule

// File: tb/intc_fiq_route_test.sv
module intc_fiq_route_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic        wr_en = 0;
  logic [31:0] rdata;
  logic [63:0] src_in = 0;
  logic        irq_o, fiq_o, wake_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_en [2];
  logic [31:0] m_st [2];
  logic        m_pol;

  always #2 clk = ~clk;

  intc_fiq_route uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .src_in(src_in), .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
  );

  function automatic logic [31:0] exp_view(int b, bit fast);
    logic [31:0] s = src_in[b*32 +: 32];
    return fast ? (s & m_en[b] & m_st[b]) : (s & m_en[b] & ~m_st[b]);
  endfunction

  function automatic logic exp_wake();
    return m_pol ? ((src_in[31:0] & m_en[0]) != 0 || (src_in[63:32] & m_en[1]) != 0)
                 : (src_in != 0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; wr_en = 0;
    @(negedge clk); v = rdata;
  endtask

  task automatic set_src(logic [63:0] v);
    @(negedge clk); src_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_outputs(string tag);
    chk({tag, " R4 irq"}, {31'b0, irq_o}, {31'b0, (exp_view(0,0) | exp_view(1,0)) != 0});
    chk({tag, " R4 fiq"}, {31'b0, fiq_o}, {31'b0, (exp_view(0,1) | exp_view(1,1)) != 0});
    chk({tag, " R6/R7 wake"}, {31'b0, wake_o}, {31'b0, exp_wake()});
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7));
    m_en[0] = 0; m_en[1] = 0; m_st[0] = 0; m_st[1] = 0; m_pol = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 outs", {29'b0, irq_o, fiq_o, wake_o}, 0);
    rd(8'h04, v); chk("R1 enable0", v, 0);
    rd(8'h28, v); chk("R1 steer1", v, 0);
    rd(8'h14, v); chk("R1 policy", v, 0);

    // R2 read back, R9 independent groups
    wr(8'h04, 32'hA5A5_0F0F); m_en[0] = 32'hA5A5_0F0F;
    wr(8'h24, 32'h1234_5678); m_en[1] = 32'h1234_5678;
    rd(8'h04, v); chk("R2 enable0", v, m_en[0]);
    rd(8'h24, v); chk("R9 enable1", v, m_en[1]);
    rd(8'h34, v); chk("R9 no policy in group1", v, 0);

    // R10 read-only and unmapped
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h00, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R10 raw untouched", v, 0);
    rd(8'h04, v); chk("R10 enable untouched", v, m_en[0]);
    rd(8'h18, v); chk("R10 unmapped", v, 0);
    rd(8'h05, v); chk("R10 unaligned", v, 0);
    rd(8'h44, v); chk("R10 beyond groups", v, 0);

    // R3 masked line stays quiet, R7 still wakes
    wr(8'h04, 0); m_en[0] = 0;
    wr(8'h24, 0); m_en[1] = 0;
    set_src(64'h0000_0001_0000_0010);
    chk("R3 irq", {31'b0, irq_o}, 0);
    chk("R3 fiq", {31'b0, fiq_o}, 0);
    chk("R7 wake", {31'b0, wake_o}, 1);
    rd(8'h10, v); chk("R5 raw0", v, 32'h10);
    rd(8'h30, v); chk("R5 raw1", v, 32'h1);
    wr(8'h14, 1); m_pol = 1;
    @(negedge clk);
    chk("R6 wake strict", {31'b0, wake_o}, 0);

    // R4 steering
    wr(8'h04, 32'h10); m_en[0] = 32'h10;
    @(negedge clk);
    chk("R4 to irq", {30'b0, irq_o, fiq_o}, 2'b10);
    rd(8'h00, v); chk("R8 irq view", v, 32'h10);
    wr(8'h08, 32'h10); m_st[0] = 32'h10;
    @(negedge clk);
    chk("R4 to fiq", {30'b0, irq_o, fiq_o}, 2'b01);
    rd(8'h0C, v); chk("R8 fiq view", v, 32'h10);
    rd(8'h00, v); chk("R8 irq view empty", v, 0);
    chk("R6 wake enabled", {31'b0, wake_o}, 1);

    // R5 falling input clears pending after two edges
    @(negedge clk); src_in = 0;
    @(negedge clk); chk("R5 one edge", {31'b0, fiq_o}, 1);
    @(negedge clk); chk("R5 two edges", {31'b0, fiq_o}, 0);

    // Enable write and line arrival in the same cycle (R2, R5)
    @(negedge clk); addr = 8'h24; wdata = 32'h8000_0000; wr_en = 1;
    src_in = 64'h8000_0000_0000_0000; m_en[1] = 32'h8000_0000;
    @(negedge clk); wr_en = 0;
    chk("R5 not yet pending", {31'b0, irq_o}, 0);
    @(negedge clk);
    chk("R2 same-cycle enable", {31'b0, irq_o}, 1);

    // R11 read sees value before same-cycle write
    @(negedge clk); addr = 8'h08; wdata = 32'h0; wr_en = 1;
    @(negedge clk); wr_en = 0; v = rdata; m_st[0] = 0;
    chk("R11 old value", v, 32'h10);
    rd(8'h08, v); chk("R11 new value", v, 0);

    // Random phase
    for (int i = 0; i < 60; i++) begin
      m_en[0] = $urandom; m_en[1] = $urandom;
      m_st[0] = $urandom; m_st[1] = $urandom;
      m_pol = $urandom_range(0, 1);
      if (i % 5 == 0) begin m_en[0] = 0; m_en[1] = 0; end
      wr(8'h04, m_en[0]); wr(8'h24, m_en[1]);
      wr(8'h08, m_st[0]); wr(8'h28, m_st[1]);
      wr(8'h14, {31'b0, m_pol});
      set_src((i % 7 == 0) ? 64'h0 : {$urandom, $urandom} & {$urandom, $urandom});
      check_outputs("rand");
      rd(8'h00, v); chk("R8 rand irq0", v, exp_view(0, 0));
      rd(8'h2C, v); chk("R8 rand fiq1", v, exp_view(1, 1));
      rd(8'h30, v); chk("R5 rand raw1", v, src_in[63:32]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule